// File: doc/BRIEF.md
# Multi-Format Serial PCM Receiver

This block receives stereo audio from a serial source that owns the bit clock and the left/right clock. The block drives neither clock. All three serial inputs (bit clock, left/right clock and data) are sampled by a faster master clock that is synchronous to them. A rising edge of the bit clock is found inside the master-clock domain. On each such edge one data bit and the current left/right level are taken.

Two frame alignments are supported. In the first, the most significant bit comes one bit slot after the left/right clock changes (I2S). In the second, it comes in the very first slot after the change (left-justified). A sample is 16 or 18 bits, sent MSB first. A half-frame is 16, 24 or 32 slots long, which gives 32x, 48x or 64x the sample rate. Slots after a sample's LSB carry nothing useful. Once a frame's right sample is complete, both samples come out together, sign-extended to 18 bits, with a valid pulse one master cycle long. A half-frame that is too short for the set precision, or whose length does not match the set ratio, raises a one-cycle error pulse, and that frame's pair is not presented.

Top module: `pcm_rx`

## Requirements
- R1: After reset, `left_o`, `right_o`, `valid_o` and `err_o` are all zero.
- R2: With `cfg_fmt_i`=1 (left-justified), the MSB is taken on the first bit-clock rising edge after a left/right clock change, and left/right clock high marks the left channel.
- R3: With `cfg_fmt_i`=0 (I2S), the MSB is taken on the second bit-clock rising edge after a left/right clock change, and left/right clock low marks the left channel.
- R4: With `cfg_prec_i`=0, each 16-bit sample is presented with bits 17 and 16 equal to bit 15.
- R5: With `cfg_prec_i`=1, each 18-bit sample is presented unchanged.
- R6: `cfg_ratio_i` 0, 1 and 2 select half-frames of 16, 24 and 32 slots. Data in the slots after the LSB has no effect on the outputs and raises no error.
- R7: `valid_o` is high for exactly one master cycle per good frame, after the right-channel LSB is taken, with that frame's left and right samples on the outputs.
- R8: With 18-bit precision at the 32x ratio, no sample completes. `valid_o` stays low and `err_o` pulses once at the end of every half-frame.
- R9: A half-frame whose slot count differs from the configured ratio pulses `err_o` at its end. A frame whose left half is bad is not presented.
- R10: Half-frames that begin before the first left/right clock change after reset give neither `valid_o` nor `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt_i | input | 1 | 0 = I2S alignment, 1 = left-justified |
| cfg_prec_i | input | 1 | 0 = 16-bit, 1 = 18-bit samples |
| cfg_ratio_i | input | 2 | 0 = 32x, 1 = 48x, 2 or 3 = 64x |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Left/right clock |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 18 | Left sample, sign-extended |
| right_o | output | 18 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new pair |
| err_o | output | 1 | One-cycle strobe for a bad half-frame |

## Verification
The assertions rely on a few properties of the inputs:
- Each bit-clock level lasts at least two master cycles, so two rising edges are never found less than two cycles apart.
- Data and the left/right clock change only while the bit clock is low.
- The configuration holds steady between resets.

The bench drives each bit-clock phase for four master cycles and changes the data and the left/right clock together with the falling edge. It changes configuration only while reset is held. It then sweeps all twelve combinations of alignment, precision and ratio, and runs one added stream with a half-frame of the wrong length.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    localparam int SAMPLE_W = 18;
    localparam int SLOT_W   = 6;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } frame_fmt_e;

    typedef enum logic [1:0] {
        RATIO_32 = 2'd0,
        RATIO_48 = 2'd1,
        RATIO_64 = 2'd2
    } ratio_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pcm_pair_t;

    typedef struct packed {
        logic rise;
        logic lr;
        logic sd;
    } bit_evt_t;

    function automatic logic [SLOT_W-1:0] half_slots(input logic [1:0] ratio);
        case (ratio)
            RATIO_32: half_slots = SLOT_W'(16);
            RATIO_48: half_slots = SLOT_W'(24);
            default:  half_slots = SLOT_W'(32);
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] prec_bits(input logic prec);
        prec_bits = prec ? SLOT_W'(18) : SLOT_W'(16);
    endfunction

    function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] raw, input logic prec);
        sext = prec ? raw : {{2{raw[15]}}, raw[15:0]};
    endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync
    import pcm_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_i,
    input  logic     lrclk_i,
    input  logic     sdata_i,
    output bit_evt_t evt_o
);

    logic [STAGES:0]   bclk_pipe;
    logic [STAGES-1:0] lr_pipe;
    logic [STAGES-1:0] sd_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_pipe <= '0;
            lr_pipe   <= '0;
            sd_pipe   <= '0;
        end else begin
            bclk_pipe[0] <= bclk_i;
            lr_pipe[0]   <= lrclk_i;
            sd_pipe[0]   <= sdata_i;
            for (int k = 1; k <= STAGES; k++) bclk_pipe[k] <= bclk_pipe[k-1];
            for (int k = 1; k < STAGES; k++) begin
                lr_pipe[k] <= lr_pipe[k-1];
                sd_pipe[k] <= sd_pipe[k-1];
            end
        end
    end

    always_comb begin
        evt_o.rise = bclk_pipe[STAGES-1] & ~bclk_pipe[STAGES];
        evt_o.lr   = lr_pipe[STAGES-1];
        evt_o.sd   = sd_pipe[STAGES-1];
    end

endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer
    import pcm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bit_evt_t          evt_i,
    input  logic              fmt_i,
    output logic              boundary_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic [SLOT_W-1:0] prev_len_o,
    output logic              chan_left_o
);

    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    logic              lr_d1, lr_d2;
    logic [1:0]        hist;
    logic [SLOT_W-1:0] slot_cnt;
    logic              cur_lr, prv_lr, armed;

    always_comb begin
        if (fmt_i == FMT_LJ) begin
            cur_lr = evt_i.lr;
            prv_lr = lr_d1;
            armed  = (hist != 2'd0);
        end else begin
            cur_lr = lr_d1;
            prv_lr = lr_d2;
            armed  = (hist == 2'd2);
        end
        boundary_o  = evt_i.rise & armed & (cur_lr != prv_lr);
        slot_idx_o  = boundary_o ? '0 : slot_cnt;
        prev_len_o  = slot_cnt;
        chan_left_o = (fmt_i == FMT_LJ) ? cur_lr : ~cur_lr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_d1    <= 1'b0;
            lr_d2    <= 1'b0;
            hist     <= 2'd0;
            slot_cnt <= '0;
        end else if (evt_i.rise) begin
            lr_d1    <= evt_i.lr;
            lr_d2    <= lr_d1;
            if (hist != 2'd2) hist <= hist + 2'd1;
            slot_cnt <= (slot_idx_o == SLOT_MAX) ? SLOT_MAX : slot_idx_o + 1'b1;
        end
    end

    // R2 R3: a new half-frame always restarts the slot count
    a_r2_restart_slot: assert property (@(posedge clk) disable iff (rst)
        boundary_o |=> (slot_cnt == SLOT_W'(1)));

endmodule

// File: rtl/pcm_rx_assembler.sv
module pcm_rx_assembler
    import pcm_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              sd_i,
    input  logic              boundary_i,
    input  logic [SLOT_W-1:0] slot_idx_i,
    input  logic [SLOT_W-1:0] prev_len_i,
    input  logic              chan_left_i,
    input  logic              prec_i,
    input  logic [1:0]        ratio_i,
    output pcm_pair_t         pair_o,
    output logic              valid_o,
    output logic              err_o
);

    logic                synced, got_lsb, left_ok;
    logic [SAMPLE_W-2:0] shreg;
    logic [SAMPLE_W-1:0] left_hold;
    pcm_pair_t           pair_q;
    logic                valid_q, err_q;

    logic [SLOT_W-1:0]   width;
    logic                capture, lsb_now, half_bad;
    logic [SAMPLE_W-1:0] word, value;

    always_comb begin
        width    = prec_bits(prec_i);
        capture  = rise_i & (synced | boundary_i) & (slot_idx_i < width);
        lsb_now  = capture & (slot_idx_i == width - 1'b1);
        word     = {shreg, sd_i};
        value    = sext(word, prec_i);
        half_bad = boundary_i & synced &
                   ((prev_len_i != half_slots(ratio_i)) | ~got_lsb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            synced    <= 1'b0;
            got_lsb   <= 1'b0;
            left_ok   <= 1'b0;
            shreg     <= '0;
            left_hold <= '0;
            pair_q    <= '0;
            valid_q   <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            if (boundary_i) begin
                synced  <= 1'b1;
                got_lsb <= 1'b0;
                if (half_bad) err_q <= 1'b1;
                if (half_bad || chan_left_i) left_ok <= 1'b0;
            end
            if (capture) shreg <= word[SAMPLE_W-2:0];
            if (lsb_now) begin
                got_lsb <= 1'b1;
                if (chan_left_i) begin
                    left_hold <= value;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    pair_q  <= '{left: left_hold, right: value};
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign pair_o  = pair_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

    // R7: the strobe lasts one cycle and follows a bit-clock rising edge
    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    a_r7_valid_after_edge: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(rise_i));
    // R8: the error strobe lasts one cycle
    a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
        err_q |=> !err_q);
    // R8: 18-bit samples never complete at the 32x ratio
    a_r8_no_valid_short: assert property (@(posedge clk) disable iff (rst)
        (prec_i && ratio_i == RATIO_32) |-> !valid_q);
    // R10: quiet until the first left/right change
    a_r10_quiet_unsynced: assert property (@(posedge clk) disable iff (rst)
        !synced |=> (!valid_q && !err_q));
    // R4: 16-bit samples carry their sign into the top bits
    a_r4_sign_ext: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !prec_i) |-> (pair_q.left[17:16] == {2{pair_q.left[15]}} &&
                                  pair_q.right[17:16] == {2{pair_q.right[15]}}));

endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
    import pcm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_fmt_i,
    input  logic        cfg_prec_i,
    input  logic [1:0]  cfg_ratio_i,
    input  logic        bclk_i,
    input  logic        lrclk_i,
    input  logic        sdata_i,
    output logic [17:0] left_o,
    output logic [17:0] right_o,
    output logic        valid_o,
    output logic        err_o
);

    bit_evt_t          evt;
    logic              boundary, chan_left;
    logic [SLOT_W-1:0] slot_idx, prev_len;
    pcm_pair_t         pair;

    pcm_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .bclk_i  (bclk_i),
        .lrclk_i (lrclk_i),
        .sdata_i (sdata_i),
        .evt_o   (evt)
    );

    pcm_rx_framer framer_i (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .fmt_i       (cfg_fmt_i),
        .boundary_o  (boundary),
        .slot_idx_o  (slot_idx),
        .prev_len_o  (prev_len),
        .chan_left_o (chan_left)
    );

    pcm_rx_assembler asm_i (
        .clk         (clk),
        .rst         (rst),
        .rise_i      (evt.rise),
        .sd_i        (evt.sd),
        .boundary_i  (boundary),
        .slot_idx_i  (slot_idx),
        .prev_len_i  (prev_len),
        .chan_left_i (chan_left),
        .prec_i      (cfg_prec_i),
        .ratio_i     (cfg_ratio_i),
        .pair_o      (pair),
        .valid_o     (valid_o),
        .err_o       (err_o)
    );

    assign left_o  = pair.left;
    assign right_o = pair.right;

endmodule

// File: tb/pcm_rx_tb_top.sv
module pcm_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt = 1'b1, prec = 1'b0;
    logic [1:0]  ratio = 2'd0;
    logic        bclk = 1'b0, lr = 1'b0, sd = 1'b0;
    logic [17:0] left_o, right_o;
    logic        valid_o, err_o;

    int total = 0, bad = 0;
    int n_valid = 0, n_err = 0;
    logic [17:0] got_l [0:7];
    logic [17:0] got_r [0:7];
    logic [17:0] exp_l [0:7];
    logic [17:0] exp_r [0:7];
    logic pend = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    pcm_rx dut_i (
        .clk(clk), .rst(rst), .cfg_fmt_i(fmt), .cfg_prec_i(prec), .cfg_ratio_i(ratio),
        .bclk_i(bclk), .lrclk_i(lr), .sdata_i(sd),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .err_o(err_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                if (n_valid < 8) begin
                    got_l[n_valid] = left_o;
                    got_r[n_valid] = right_o;
                end
                n_valid++;
            end
            if (err_o) n_err++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] exp_val(input logic [17:0] v, input logic p);
        return p ? v : {{2{v[15]}}, v[15:0]};
    endfunction

    task automatic slot(input logic lrv, input logic b);
        lr = lrv;
        sd = b;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
    endtask

    task automatic send_half(input logic lrv, input logic [17:0] val, input int len, input int w);
        for (int s = 0; s < len; s++) begin
            logic b, o;
            b = (s < w) ? val[w-1-s] : ~s[0];
            if (fmt == 1'b0) begin
                o = pend;
                pend = b;
            end else o = b;
            slot(lrv, o);
        end
    endtask

    task automatic start_cfg(input logic f, input logic p, input logic [1:0] r);
        @(negedge clk);
        rst = 1'b1;
        fmt = f; prec = p; ratio = r;
        bclk = 1'b0; lr = ~f; sd = 1'b0; pend = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_valid = 0;
        n_err = 0;
    endtask

    task automatic run_cfg(input logic f, input logic p, input logic [1:0] r, input int ci);
        int w, half, nf;
        logic lft;
        logic [17:0] mask;
        w = p ? 18 : 16;
        half = (r == 2'd0) ? 16 : (r == 2'd1) ? 24 : 32;
        mask = p ? 18'h3FFFF : 18'h0FFFF;
        nf = 3;
        lft = f;
        start_cfg(f, p, r);
        send_half(~lft, 18'h0, 6, w);
        for (int fi = 0; fi < nf; fi++) begin
            exp_l[fi] = 18'((fi * 20011 + ci * 977 + 32'h20001)) & mask;
            exp_r[fi] = 18'((fi * 12347 + ci * 331 + 32'h0AAAA) ^ 32'h28000) & mask;
            send_half(lft, exp_l[fi], half, w);
            send_half(~lft, exp_r[fi], half, w);
        end
        send_half(lft, 18'h0, 3, w);
        repeat (10) @(negedge clk);
        if (p && r == 2'd0) begin
            check(n_valid == 0, "R8 no pair at 18-bit 32x", n_valid, 0);
            check(n_err == 2 * nf, "R8 error per half-frame (R10 pre-sync half silent)", n_err, 2 * nf);
        end else begin
            check(n_valid == nf, "R7 one pulse per frame", n_valid, nf);
            check(n_err == 0, "R6 trailing slots ignored, R10 no early error", n_err, 0);
            for (int fi = 0; fi < nf; fi++) begin
                string tg;
                tg = $sformatf("%s %s ratio%0d frame%0d",
                               f ? "R2 left-justified" : "R3 I2S",
                               p ? "R5 18-bit" : "R4 16-bit", r, fi);
                check(got_l[fi] == exp_val(exp_l[fi], p), {tg, " left"}, got_l[fi], exp_val(exp_l[fi], p));
                check(got_r[fi] == exp_val(exp_r[fi], p), {tg, " right"}, got_r[fi], exp_val(exp_r[fi], p));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(left_o == 18'h0 && right_o == 18'h0, "R1 reset samples", left_o, 0);
        check(!valid_o && !err_o, "R1 reset strobes", {valid_o, err_o}, 0);
        begin
            int ci;
            ci = 0;
            for (int f = 0; f < 2; f++)
                for (int p = 0; p < 2; p++)
                    for (int r = 0; r < 3; r++) begin
                        run_cfg(f[0], p[0], r[1:0], ci);
                        ci++;
                    end
        end
        // R9: a left half of 20 slots at 48x spoils that frame only
        start_cfg(1'b1, 1'b0, 2'd1);
        send_half(1'b0, 18'h0, 6, 16);
        send_half(1'b1, 18'h0F00F, 24, 16);
        send_half(1'b0, 18'h08421, 24, 16);
        send_half(1'b1, 18'h01234, 20, 16);
        send_half(1'b0, 18'h05678, 24, 16);
        send_half(1'b1, 18'h0ABCD, 24, 16);
        send_half(1'b0, 18'h0FEDC, 24, 16);
        send_half(1'b1, 18'h0, 3, 16);
        repeat (10) @(negedge clk);
        check(n_err == 1, "R9 error on wrong half length", n_err, 1);
        check(n_valid == 2, "R9 spoiled frame not presented", n_valid, 2);
        check(got_l[1] == 18'h3ABCD && got_r[1] == 18'h3FEDC, "R9 next frame intact", got_l[1], 18'h3ABCD);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule